// File: doc/BRIEF.md
# Crystal-Referenced Speed Discriminator

This block measures the speed of a motor from a digitized tachometer pulse train and compares it with a speed set by the reference clock. The reference clock is first divided by a prescaler. The number of prescaled ticks between tachometer rising edges gives the length of each revolution step. Each pair of consecutive steps is summed and compared against twice the nominal count. The result is a signed frequency error, an accelerate/decelerate flag and an active-low lock flag. The lock flag is asserted when the average step is within ±6.25 % of nominal.

A second path runs a reference phase counter that wraps once every nominal count of ticks. For every tachometer cycle it produces a phase pulse. The pulse lasts from whichever comes first, the tachometer edge or the reference wrap, until the other one arrives. A sign output tells which of the two came first. A downstream integrator can turn the frequency error and the phase pulses into a drive level.

Top module: `spd_discrim`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `lock_n`=1, `accel`=0, `freq_vld`=0, `freq_err`=0, `phase_pulse`=0 and `phase_lag`=0.
- R2: Raising `rst` synchronously in the middle of operation clears the outputs to the R1 values one clock later, even when the block was locked.
- R3: `fg_in` passes through a two-flop synchronizer. The length of each step is the number of ticks of `clk`/PRESCALE between two synchronized rising edges, so a step of PRESCALE·N clocks measures as N.
- R4: A frequency evaluation happens once for every two completed steps. `freq_vld` is high for exactly one cycle per evaluation, and consecutive pulses are two step lengths apart.
- R5: At each evaluation, `freq_err` = T − 2·NOMINAL as a two's-complement value of CNT_W+2 bits, where T is the sum of the two step counts.
- R6: At each evaluation, `accel` becomes 1 if T > 2·NOMINAL (the motor is slow) and 0 otherwise. `accel`, `lock_n` and `freq_err` hold their values between evaluations.
- R7: At each evaluation, `lock_n` becomes 0 when 2·(NOMINAL−LOCK_TOL) ≤ T ≤ 2·(NOMINAL+LOCK_TOL), which is 960 to 1088 with the defaults; otherwise it becomes 1.
- R8: The step counter stops at 2^CNT_W−1 instead of wrapping. While it is stopped there (the motor has stalled), `lock_n` is 1 and `accel` is 1.
- R9: A reference edge occurs every NOMINAL ticks. `phase_pulse` goes high in the cycle after the first of {FG rising edge, reference edge} and low in the cycle after the other one. `phase_lag` is 1 during the pulse when the reference edge came first. If both events fall in the same cycle, no pulse is produced.
- R10: When the step length equals NOMINAL·PRESCALE clocks, one phase pulse of constant width appears per step. Delaying the FG edges by D clocks changes that width by D: it shrinks when FG leads and grows when FG lags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fg_in | input | 1 | Digitized tachometer pulse, asynchronous |
| freq_vld | output | 1 | One-cycle strobe marking a new frequency evaluation |
| freq_err | output | CNT_W+2 | Signed two-step count minus twice nominal |
| accel | output | 1 | 1 requests acceleration, 0 requests deceleration |
| lock_n | output | 1 | 0 while the speed is inside the lock window |
| phase_pulse | output | 1 | High for the time between the FG edge and the reference edge |
| phase_lag | output | 1 | 1 when FG lags the reference edge |

## Verification
The assertions assume that two synchronized FG rising edges are at least two clocks apart and that PRESCALE is at least 2. Under these conditions ticks and evaluations never occur in back-to-back cycles. The stimulus drives FG with periods of hundreds to thousands of clocks, always with a high phase of half a period, and sets every input on the falling clock edge. The bench uses a prescaler of 4, so stall saturation and several evaluations fit in a short run. All counts are chosen as whole multiples of that prescaler, so every step measures an exact tick count.

// File: rtl/spd_pkg.sv
package spd_pkg;
    // which event opened the current phase window
    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_FG_FIRST  = 2'd1,
        PH_REF_FIRST = 2'd2
    } ph_state_e;
endpackage

// File: rtl/spd_fg_edge.sv
module spd_fg_edge (
    input  logic clk,
    input  logic rst,
    input  logic fg_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = fg_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;

    // R3: one event per synchronized edge
    a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/spd_prescaler.sv
module spd_prescaler #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PS_W = $clog2(PRESCALE);
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0] div_d, div_q;

    always_comb begin
        if (div_q == PS_LAST) div_d = '0;
        else                  div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign tick = (div_q == PS_LAST);

    // R3: ticks are isolated single-cycle strobes
    a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/spd_period_meter.sv
module spd_period_meter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rise,
    output logic             pair_vld,
    output logic [CNT_W:0]   pair_sum,
    output logic             stalled
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] first;
        logic             armed;
        logic             half;
        logic             vld;
        logic [SUM_W-1:0] sum;
    } meter_t;

    meter_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        if (st_q.cnt == CNT_MAX) cnt_inc = CNT_MAX;
        else                     cnt_inc = st_q.cnt + CNT_W'(tick);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (rise) begin
            st_d.cnt = '0;
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
            end else if (!st_q.half) begin
                st_d.first = cnt_inc;
                st_d.half  = 1'b1;
            end else begin
                st_d.sum  = SUM_W'(st_q.first) + SUM_W'(cnt_inc);
                st_d.vld  = 1'b1;
                st_d.half = 1'b0;
            end
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pair_vld = st_q.vld;
    assign pair_sum = st_q.sum;
    assign stalled  = (st_q.cnt == CNT_MAX);

    // R8: a saturated counter stays saturated until an edge arrives
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (!rise && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));
endmodule

// File: rtl/spd_phase_det.sv
module spd_phase_det
    import spd_pkg::*;
#(
    parameter int NOMINAL = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rise,
    output logic pulse,
    output logic lag
);
    localparam int REF_W = $clog2(NOMINAL);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(NOMINAL - 1);

    typedef struct packed {
        logic [REF_W-1:0] refc;
        ph_state_e        ph;
        logic             pulse;
        logic             lag;
    } phase_t;

    phase_t st_d, st_q;
    logic   ref_edge;

    assign ref_edge = tick && (st_q.refc == REF_LAST);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.refc == REF_LAST) st_d.refc = '0;
            else                       st_d.refc = st_q.refc + 1'b1;
        end
        unique case (st_q.ph)
            PH_IDLE: begin
                if (rise && !ref_edge)      st_d.ph = PH_FG_FIRST;
                else if (ref_edge && !rise) st_d.ph = PH_REF_FIRST;
                else                        st_d.ph = PH_IDLE;
            end
            PH_FG_FIRST:  if (ref_edge) st_d.ph = PH_IDLE;
            PH_REF_FIRST: if (rise)     st_d.ph = PH_IDLE;
            default:      st_d.ph = PH_IDLE;
        endcase
        st_d.pulse = (st_d.ph != PH_IDLE);
        st_d.lag   = (st_d.ph == PH_REF_FIRST);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{refc: '0, ph: PH_IDLE, pulse: 1'b0, lag: 1'b0};
        else     st_q <= st_d;
    end

    assign pulse = st_q.pulse;
    assign lag   = st_q.lag;

    // R9: the lag sign is only raised together with a pulse
    a_r9_lag_in_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(lag) |-> pulse);
    // R9: a window opened by FG closes only on a reference edge
    a_r9_fg_window_close: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_FG_FIRST && !ref_edge) |=> pulse);
endmodule

// File: rtl/spd_discrim.sv
module spd_discrim #(
    parameter int PRESCALE = 16,
    parameter int NOMINAL  = 512,
    parameter int LOCK_TOL = 32,
    parameter int CNT_W    = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fg_in,
    output logic               freq_vld,
    output logic [CNT_W+1:0]   freq_err,
    output logic               accel,
    output logic               lock_n,
    output logic               phase_pulse,
    output logic               phase_lag
);
    localparam int SUM_W = CNT_W + 1;
    localparam int ERR_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] TARGET  = SUM_W'(2 * NOMINAL);
    localparam logic [SUM_W-1:0] WIN_LO  = SUM_W'(2 * (NOMINAL - LOCK_TOL));
    localparam logic [SUM_W-1:0] WIN_HI  = SUM_W'(2 * (NOMINAL + LOCK_TOL));

    typedef struct packed {
        logic             vld;
        logic [ERR_W-1:0] err;
        logic             accel;
        logic             lock_n;
    } decide_t;

    logic             fg_rise;
    logic             ps_tick;
    logic             pair_vld;
    logic [SUM_W-1:0] pair_sum;
    logic             stalled;
    decide_t          dc_d, dc_q;

    spd_fg_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .fg_in (fg_in),
        .rise  (fg_rise)
    );

    spd_prescaler #(.PRESCALE(PRESCALE)) u_ps (
        .clk  (clk),
        .rst  (rst),
        .tick (ps_tick)
    );

    spd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .tick     (ps_tick),
        .rise     (fg_rise),
        .pair_vld (pair_vld),
        .pair_sum (pair_sum),
        .stalled  (stalled)
    );

    spd_phase_det #(.NOMINAL(NOMINAL)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .tick  (ps_tick),
        .rise  (fg_rise),
        .pulse (phase_pulse),
        .lag   (phase_lag)
    );

    always_comb begin
        dc_d     = dc_q;
        dc_d.vld = pair_vld;
        if (pair_vld) begin
            dc_d.err    = ERR_W'(pair_sum) - ERR_W'(TARGET);
            dc_d.accel  = (pair_sum > TARGET);
            dc_d.lock_n = !((pair_sum >= WIN_LO) && (pair_sum <= WIN_HI));
        end
        if (stalled) begin
            dc_d.accel  = 1'b1;
            dc_d.lock_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dc_q <= '{vld: 1'b0, err: '0, accel: 1'b0, lock_n: 1'b1};
        else     dc_q <= dc_d;
    end

    assign freq_vld = dc_q.vld;
    assign freq_err = dc_q.err;
    assign accel    = dc_q.accel;
    assign lock_n   = dc_q.lock_n;

    // R4: each evaluation strobe lasts a single cycle
    a_r4_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        freq_vld |=> !freq_vld);
    // R7: lock is only gained at an evaluation
    a_r7_lock_on_eval: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> freq_vld);
    // R6: the error word only moves at an evaluation
    a_r6_err_hold: assert property (@(posedge clk) disable iff (rst)
        !freq_vld |-> $stable(freq_err));
endmodule

// File: tb/sim_spd_discrim.sv
module sim_spd_discrim;
    localparam int PS    = 4;
    localparam int NOM   = 512;
    localparam int CW    = 11;
    localparam int REFP  = NOM * PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fg  = 1'b0;
    logic              freq_vld;
    logic [CW+1:0]     freq_err;
    logic              accel, lock_n, phase_pulse, phase_lag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bit fg_run  = 0;
    int per_a   = REFP;
    int per_b   = REFP;
    int shift_d = 0;
    int cur, ext;
    bit sel     = 0;

    always #10 clk = ~clk;

    spd_discrim #(.PRESCALE(PS), .NOMINAL(NOM), .LOCK_TOL(32), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .fg_in(fg),
        .freq_vld(freq_vld), .freq_err(freq_err), .accel(accel),
        .lock_n(lock_n), .phase_pulse(phase_pulse), .phase_lag(phase_lag)
    );

    // FG generator, period taken at the start of each cycle
    initial begin
        forever begin
            if (!fg_run) begin
                fg = 1'b0;
                @(negedge clk);
            end else begin
                cur = sel ? per_b : per_a;
                sel = ~sel;
                ext = shift_d;
                shift_d = 0;
                fg = 1'b1;
                repeat (cur / 2) @(negedge clk);
                fg = 1'b0;
                repeat (cur - cur / 2 + ext) @(negedge clk);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_vld();
        do @(negedge clk); while (!freq_vld);
    endtask

    task automatic run_pair(input int na, input int nb);
        per_a = na * PS;
        per_b = nb * PS;
        fg_run = 1;
        repeat (3) wait_vld();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 lock_n", lock_n, 1);
        chk("R1 accel", accel, 0);
        chk("R1 freq_vld", freq_vld, 0);
        chk("R1 freq_err", int'($signed(freq_err)), 0);
        chk("R1 phase_pulse", phase_pulse, 0);
        chk("R1 phase_lag", phase_lag, 0);
    endtask

    task automatic t_speed(input string nm, input int na, input int nb,
                           input int e_err, input int e_acc, input int e_lk);
        run_pair(na, nb);
        chk({nm, " R3 R5 freq_err"}, int'($signed(freq_err)), e_err);
        chk({nm, " R6 accel"}, accel, e_acc);
        chk({nm, " R7 lock_n"}, lock_n, e_lk);
    endtask

    task automatic t_interval();
        int n = 0;
        run_pair(NOM, NOM);
        do begin @(negedge clk); n++; end while (!freq_vld);
        chk("R4 evaluation spacing", n, 2 * REFP);
        @(negedge clk);
        chk("R4 strobe width", freq_vld, 0);
    endtask

    task automatic t_stall();
        run_pair(NOM, NOM);
        fg_run = 0;
        wait (fg == 1'b0);
        repeat (4000) @(negedge clk);
        chk("R6 lock held before stall", lock_n, 0);
        chk("R6 accel held before stall", accel, 0);
        repeat (4300) @(negedge clk);
        chk("R8 stall lock_n", lock_n, 1);
        chk("R8 stall accel", accel, 1);
    endtask

    task automatic meas_pulse(output int w, output int lg);
        w = 0;
        do @(negedge clk); while (phase_pulse);
        do @(negedge clk); while (!phase_pulse);
        lg = phase_lag;
        while (phase_pulse) begin w++; @(negedge clk); end
    endtask

    task automatic t_phase();
        int w1, l1, w2, l2, w3, l3, d, ew;
        run_pair(NOM, NOM);
        meas_pulse(w1, l1);
        meas_pulse(w2, l2);
        chk("R10 width stable", w2, w1);
        chk("R10 sign stable", l2, l1);
        if (l1 == 0) begin d = w1 / 2; ew = w1 - d; end
        else begin d = (REFP - w1) / 4; ew = w1 + d; end
        shift_d = d;
        repeat (3 * REFP) @(negedge clk);
        meas_pulse(w3, l3);
        chk("R9 R10 shifted width", w3, ew);
        chk("R9 shifted sign", l3, l1);
    endtask

    task automatic t_midreset();
        run_pair(NOM, NOM);
        chk("R2 locked before reset", lock_n, 0);
        rst = 1'b1;
        @(negedge clk);
        chk("R2 lock_n", lock_n, 1);
        chk("R2 accel", accel, 0);
        chk("R2 freq_err", int'($signed(freq_err)), 0);
        chk("R2 phase_pulse", phase_pulse, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_speed("nominal", 512, 512, 0, 0, 0);
        t_interval();
        t_stall();
        t_speed("low edge", 480, 480, -64, 0, 0);
        t_speed("below", 479, 479, -66, 0, 1);
        t_speed("high edge", 544, 544, 64, 1, 0);
        t_speed("above", 545, 545, 66, 1, 1);
        t_speed("unequal", 500, 530, 6, 1, 0);
        t_phase();
        t_midreset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule